// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block takes a 32-bit request vector and reports the position of the highest-numbered request that is set. It is purely combinational and is built from four copies of one 8-input slice. Each slice answers for its own byte of the request vector, and the slices are chained from the top byte to the bottom byte by a pass-down enable. A slice passes the enable to the slice below only when it is enabled and none of its own requests is set. So a set request in a higher byte hides every request in the lower bytes.

The 5-bit result is built from two parts. The two upper bits name the slice that claimed the request. The three lower bits come from that slice's local index. A disabled or idle slice drives a local index of zero, so the lower bits are a plain OR of all local indices and need no multiplexer. Two flags go with the index. The group flag says that some request was found. The enable-out flag says that the block was enabled but found no request. Because the enable-out flag is taken from the bottom slice, a wider encoder can be built by chaining several of these blocks.

Top module: `prio_enc_cascade`

## Requirements
- R1: When `en_i` is 1 and at least one bit of `req_i` is 1, `idx_o` equals the position of the highest-numbered bit of `req_i` that is 1.
- R2: `grp_sel_o` is 1 exactly when `en_i` is 1 and at least one bit of `req_i` is 1.
- R3: `en_out_o` is 1 exactly when `en_i` is 1 and every bit of `req_i` is 0.
- R4: When `en_i` is 0, `idx_o` is 0 and both `grp_sel_o` and `en_out_o` are 0, whatever the value of `req_i`.
- R5: `idx_o[4:3]` names the byte that holds the winning request: 3 for bits 31..24, 2 for 23..16, 1 for 15..8 and 0 for 7..0. `idx_o[2:0]` is the bit position inside that byte.
- R6: `grp_sel_o` and `en_out_o` are never both 1.
- R7: When a higher byte holds a set request, set requests in the lower bytes have no effect on `idx_o`.
- R8: Inside the winning byte, set requests below the highest one in that byte have no effect on `idx_o`.
- R9: When `en_i` is 1 and `req_i` is all zero, `idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 32 | Request vector; a higher bit number has higher priority |
| en_i | input | 1 | Enables the encoder; feeds the slice for bits 31..24 |
| idx_o | output | 5 | Position of the highest set request |
| grp_sel_o | output | 1 | High when enabled and at least one request is set |
| en_out_o | output | 1 | High when enabled and no request is set; for chaining |

## Verification
The embedded checks watch, on every input change, that the two flags are never both high and that at most one slice claims a request. They also check that a disabled block stays silent, and that whenever a request is found, the bit at the reported index is set and no bit above it is set. Those checks alone cannot show that an idle block reports index zero, that the flags match the exact input (R2, R3), or that requests in lower bytes and in lower bits of the same byte are fully masked. The scenarios cover these points: the all-zero pattern, every single-bit pattern, hand-made patterns with requests in several bytes, and random dense and sparse patterns, all checked against an independent loop model.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

    // Geometry of the cascade
    localparam int PE_SLICE_W    = 8;
    localparam int PE_NUM_SLICES = 4;
    localparam int PE_REQ_W      = PE_SLICE_W * PE_NUM_SLICES;
    localparam int PE_LIDX_W     = $clog2(PE_SLICE_W);
    localparam int PE_GIDX_W     = $clog2(PE_NUM_SLICES);
    localparam int PE_IDX_W      = PE_LIDX_W + PE_GIDX_W;

    typedef logic [PE_SLICE_W-1:0] slice_req_t;
    typedef logic [PE_LIDX_W-1:0]  local_idx_t;
    typedef logic [PE_GIDX_W-1:0]  group_idx_t;
    typedef logic [PE_IDX_W-1:0]   full_idx_t;

    // Result of one slice
    typedef struct packed {
        local_idx_t idx;
        logic       en_out;
        logic       grp_sel;
    } slice_res_t;

    // Position of the highest set bit of a slice request; zero when none
    function automatic local_idx_t top_bit_pos(input slice_req_t r);
        local_idx_t p;
        p = '0;
        for (int i = 0; i < PE_SLICE_W; i++) begin
            if (r[i]) p = local_idx_t'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/pe_slice.sv
module pe_slice
    import prio_enc_pkg::*;
(
    input  slice_req_t req_i,
    input  logic       en_i,
    output slice_res_t res_o
);

    logic       any_req;
    local_idx_t raw_idx;

    always_comb begin
        any_req = |req_i;
        raw_idx = top_bit_pos(req_i);
        res_o.grp_sel = en_i & any_req;
        res_o.en_out  = en_i & ~any_req;
        res_o.idx     = res_o.grp_sel ? raw_idx : '0;
    end

    // R8: a claimed local index points at a set bit with nothing set above it
    always_comb begin
        if (res_o.grp_sel) begin
            p_slice_pick_r8: assert ((req_i >> res_o.idx) == slice_req_t'(1))
                else $error("slice picked a bit that is not the highest set one");
        end
    end

    // R4: a disabled slice is silent
    always_comb begin
        if (!en_i) begin
            p_slice_quiet_r4: assert (res_o.idx == '0 && !res_o.en_out && !res_o.grp_sel)
                else $error("disabled slice drove an output");
        end
    end

endmodule

// File: rtl/pe_merge.sv
module pe_merge
    import prio_enc_pkg::*;
(
    input  slice_res_t [PE_NUM_SLICES-1:0] res_i,
    output full_idx_t                      idx_o,
    output logic                           grp_sel_o,
    output logic                           en_out_o
);

    logic [PE_NUM_SLICES-1:0] grp_vec;
    group_idx_t               gidx;
    local_idx_t               lidx;

    always_comb begin
        gidx = '0;
        lidx = '0;
        for (int s = 0; s < PE_NUM_SLICES; s++) begin
            grp_vec[s] = res_i[s].grp_sel;
            if (res_i[s].grp_sel) gidx = gidx | group_idx_t'(s);
            lidx = lidx | res_i[s].idx;
        end
        idx_o     = {gidx, lidx};
        grp_sel_o = |grp_vec;
        en_out_o  = res_i[0].en_out;
    end

    // R5: at most one slice claims a request, so the group bits are unambiguous
    always_comb begin
        p_single_claim_r5: assert ($onehot0(grp_vec))
            else $error("more than one slice claimed a request");
    end

endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade
    import prio_enc_pkg::*;
(
    input  logic [31:0] req_i,
    input  logic        en_i,
    output logic [4:0]  idx_o,
    output logic        grp_sel_o,
    output logic        en_out_o
);

    slice_res_t [PE_NUM_SLICES-1:0] res;
    logic       [PE_NUM_SLICES:0]   chain_en;

    assign chain_en[PE_NUM_SLICES] = en_i;

    for (genvar s = 0; s < PE_NUM_SLICES; s++) begin : g_slice
        pe_slice u_slice (
            .req_i (req_i[s*PE_SLICE_W +: PE_SLICE_W]),
            .en_i  (chain_en[s+1]),
            .res_o (res[s])
        );
        assign chain_en[s] = res[s].en_out;
    end

    pe_merge u_merge (
        .res_i     (res),
        .idx_o     (idx_o),
        .grp_sel_o (grp_sel_o),
        .en_out_o  (en_out_o)
    );

    // R1: reported index is set and nothing above it is set
    always_comb begin
        if (grp_sel_o) begin
            p_top_index_r1: assert ((req_i >> idx_o) == 32'd1)
                else $error("index is not the highest set request");
        end
    end

    // R4: disabled block drives nothing
    always_comb begin
        if (!en_i) begin
            p_disabled_quiet_r4: assert (idx_o == '0 && !grp_sel_o && !en_out_o)
                else $error("disabled block drove an output");
        end
    end

    // R6: flags are mutually exclusive
    always_comb begin
        p_flags_exclusive_r6: assert (!(grp_sel_o && en_out_o))
            else $error("group and enable-out flags both high");
    end

endmodule

// File: tb/prio_enc_cascade_bench.sv
module prio_enc_cascade_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req;
    logic        en;
    logic [4:0]  idx;
    logic        gs;
    logic        eo;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    prio_enc_cascade u_prio_enc_cascade (
        .req_i     (req),
        .en_i      (en),
        .idx_o     (idx),
        .grp_sel_o (gs),
        .en_out_o  (eo)
    );

    typedef struct {
        logic [4:0] idx;
        logic       gs;
        logic       eo;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // Independent model straight from the requirements
    function automatic exp_t model(input logic [31:0] r, input logic e, input string tag);
        exp_t x;
        x.idx = 5'd0;
        x.gs  = 1'b0;
        x.eo  = 1'b0;
        x.tag = tag;
        if (e) begin
            x.eo = 1'b1;
            for (int i = 31; i >= 0; i--) begin
                if (r[i] && !x.gs) begin
                    x.idx = 5'(i);
                    x.gs  = 1'b1;
                    x.eo  = 1'b0;
                end
            end
        end
        return x;
    endfunction

    task automatic drive(input logic [31:0] r, input logic e, input string tag);
        @(posedge clk);
        #1;
        req = r;
        en  = e;
        sb.push_back(model(r, e, tag));
    endtask

    task automatic drive_exp(input logic [31:0] r, input logic [4:0] want, input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        req = r;
        en  = 1'b1;
        x.idx = want;
        x.gs  = 1'b1;
        x.eo  = 1'b0;
        x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            sb.delete();
        end else if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            checks++;
            if (idx !== x.idx || gs !== x.gs || eo !== x.eo) begin
                failures++;
                $display("FAIL %s: req=%h en=%b got idx=%0d gs=%b eo=%b expected idx=%0d gs=%b eo=%b",
                         x.tag, req, en, idx, gs, eo, x.idx, x.gs, x.eo);
            end
        end
    end

    initial begin
        req = '0;
        en  = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        // Idle state after reset: disabled, no requests (R4)
        drive(32'h0, 1'b0, "R4 idle");
        // All-zero input while enabled (R3, R9)
        drive(32'h0, 1'b1, "R3 R9 all zero");
        // Every single-bit request (R1, R2, R5)
        for (int i = 0; i < 32; i++) drive(32'h1 << i, 1'b1, "R1 R2 R5 single bit");
        // Disabled with traffic (R4)
        drive(32'hFFFF_FFFF, 1'b0, "R4 disabled all ones");
        drive(32'h8000_0001, 1'b0, "R4 disabled sparse");
        // Cross-byte masking (R7) with explicit expected indices
        drive_exp(32'h0800_0020, 5'd27, "R7 byte3 over byte0");
        drive_exp(32'h0001_FFFF, 5'd16, "R7 byte2 over bytes1,0");
        drive_exp(32'h0000_01FF, 5'd8,  "R7 byte1 over byte0");
        // Within-byte masking (R8)
        drive_exp(32'h0000_00FF, 5'd7,  "R8 full low byte");
        drive_exp(32'h0000_5500, 5'd14, "R8 alternating byte1");
        drive_exp(32'h0000_0003, 5'd1,  "R8 two lowest bits");
        // Group bits of the index (R5)
        drive_exp(32'h00C0_0000, 5'd23, "R5 group 2 top");
        drive_exp(32'h1000_0000, 5'd28, "R5 group 3");
        // Random dense and sparse patterns (R1, R2, R3, R6)
        for (int n = 0; n < 300; n++) drive($urandom(), 1'b1, "R1 R2 R6 random dense");
        for (int n = 0; n < 200; n++)
            drive(($urandom() & $urandom() & $urandom()) >> ($urandom() % 32), 1'b1,
                  "R1 R3 R6 random sparse");
        for (int n = 0; n < 40; n++) drive($urandom(), 1'b0, "R4 random disabled");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule